// File: doc/BRIEF.md
# Monochrome CRT Drive Timing Generator

This block produces the three separate signals that a 12-inch monochrome monitor needs: an active-low horizontal drive pulse, an active-low vertical drive pulse and an active-high video bit. The monitor scans at 50 Hz and 20 kHz. A one-cycle clock enable paces the block at 1 MHz, so each accepted enable is one microsecond of screen time. A tick counter times each 50 us line. A line counter times each 400-line frame. A row counter splits the active area into 10-line character rows.

A small built-in test pattern is gated into the active window. A 2-bit select input picks the pattern. The block samples the select only when a new frame begins, so a picture is never torn mid-frame. The block is meant for a bench fixture that exercises a monitor when no host computer is attached.

Top module: `crt_drive_gen`

## Requirements
- R1: A line lasts 50 accepted ticks, numbered 0 to 49. `hdrive_n` is low on ticks 0 to 14 and high on ticks 15 to 49.
- R2: A frame lasts 400 lines, numbered 0 to 399, which is 20000 ticks. `vdrive_n` is low for 800 consecutive ticks in each frame.
- R3: `vdrive_n` falls on tick 9 of line 0 and rises on tick 9 of line 16.
- R4: `video` is high only on ticks 10 to 49 of lines 80 to 329.
- R5: Pattern codes are as follows.
  - Code 0 is dark.
  - Code 1 is vertical bars: a tick is lit when floor((tick-10)/4) is even.
  - Code 2 lights the whole window.
  - Code 3 is dark.
- R6: Inside the active lines, the lines where (line-80) mod 10 is 8 or 9 are always dark, whatever the pattern.
- R7: While `rst` is high, and until the first enable after it, the tick and line counts are 0. In that state `hdrive_n` is 0, `vdrive_n` is 1 and `video` is 0. The pattern stays at code 0 until the first frame wrap.
- R8: `pat_sel` is sampled only on the enable that moves from line 399, tick 49 to line 0, tick 0. A change at any other time has no effect on `video` during the current frame.
- R9: While `tick_en` is low, the counters do not advance and all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable, one per microsecond |
| pat_sel | input | 2 | Test pattern code, sampled at frame start |
| hdrive_n | output | 1 | Horizontal drive, active low |
| vdrive_n | output | 1 | Vertical drive, active low |
| video | output | 1 | Video bit, active high |

## Verification
On every cycle, the bound checker confirms the following:
- `video` never leaves the active window or lights a row's two spacer lines.
- Each drive edge lands on its programmed tick and line.
- The pattern register changes only at the frame wrap.
- Nothing moves while the enable is low.

The drive periods are checked only by the bench, which counts accepted ticks between successive falling edges. The bench scenarios alone show the exact bar and block shapes. They also show the effect of a select change made mid-frame, and that the reset frame stays dark even when a pattern is requested.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef enum logic [1:0] {
        PAT_DARK  = 2'd0,
        PAT_BARS  = 2'd1,
        PAT_SOLID = 2'd2,
        PAT_SPARE = 2'd3
    } pattern_e;

    typedef struct packed {
        logic hdrive_n;
        logic vdrive_n;
        logic video;
    } drive_t;

    localparam int DEF_LINE_TICKS   = 50;
    localparam int DEF_HDRIVE_TICKS = 15;
    localparam int DEF_FRAME_LINES  = 400;
    localparam int DEF_VDRIVE_LINES = 16;
    localparam int DEF_VDRIVE_DELAY = 9;
    localparam int DEF_VIDEO_START  = 10;
    localparam int DEF_ACTIVE_FIRST = 80;
    localparam int DEF_ACTIVE_LINES = 250;
    localparam int DEF_ROW_LINES    = 10;
    localparam int DEF_LIT_LINES    = 8;
    localparam int DEF_BAR_TICKS    = 4;

    // Bar phase: even bar index is lit.
    function automatic logic bar_lit(input int offset, input int bar_ticks);
        return ((offset / bar_ticks) % 2) == 0;
    endfunction

endpackage

// File: rtl/crt_tick_ctr.sv
module crt_tick_ctr #(
    parameter int LINE_TICKS = 50,
    localparam int TW = $clog2(LINE_TICKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    output logic [TW-1:0] tick_q,
    output logic          line_end
);
    localparam logic [TW-1:0] TICK_LAST = TW'(LINE_TICKS - 1);

    assign line_end = tick_en && (tick_q == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else if (tick_en) begin
            if (tick_q == TICK_LAST) tick_q <= '0;
            else                     tick_q <= tick_q + TW'(1);
        end
    end
endmodule

// File: rtl/crt_line_ctr.sv
module crt_line_ctr #(
    parameter int FRAME_LINES  = 400,
    parameter int ACTIVE_FIRST = 80,
    parameter int ROW_LINES    = 10,
    localparam int LW = $clog2(FRAME_LINES),
    localparam int RW = $clog2(ROW_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    output logic [LW-1:0] line_q,
    output logic [RW-1:0] row_q,
    output logic          frame_end
);
    localparam logic [LW-1:0] LINE_LAST  = LW'(FRAME_LINES - 1);
    localparam logic [LW-1:0] PRE_ACTIVE = LW'(ACTIVE_FIRST - 1);
    localparam logic [RW-1:0] ROW_LAST   = RW'(ROW_LINES - 1);

    assign frame_end = line_end && (line_q == LINE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            row_q  <= '0;
        end else if (line_end) begin
            if (line_q == LINE_LAST) line_q <= '0;
            else                     line_q <= line_q + LW'(1);
            // Row position restarts as the first active line begins.
            if (line_q == PRE_ACTIVE || row_q == ROW_LAST) row_q <= '0;
            else                                           row_q <= row_q + RW'(1);
        end
    end
endmodule

// File: rtl/crt_pattern_gen.sv
module crt_pattern_gen
    import crt_pkg::*;
#(
    parameter int LINE_TICKS   = 50,
    parameter int FRAME_LINES  = 400,
    parameter int VIDEO_START  = 10,
    parameter int ACTIVE_FIRST = 80,
    parameter int ACTIVE_LINES = 250,
    parameter int ROW_LINES    = 10,
    parameter int LIT_LINES    = 8,
    parameter int BAR_TICKS    = 4,
    localparam int TW = $clog2(LINE_TICKS),
    localparam int LW = $clog2(FRAME_LINES),
    localparam int RW = $clog2(ROW_LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_end,
    input  logic [1:0]    pat_sel,
    input  logic [TW-1:0] tick_q,
    input  logic [LW-1:0] line_q,
    input  logic [RW-1:0] row_q,
    output pattern_e      pat_q,
    output logic          video
);
    localparam logic [LW-1:0] FIRST_L = LW'(ACTIVE_FIRST);
    localparam logic [LW-1:0] END_L   = LW'(ACTIVE_FIRST + ACTIVE_LINES);
    localparam logic [TW-1:0] START_T = TW'(VIDEO_START);
    localparam logic [RW-1:0] LIT_R   = RW'(LIT_LINES);

    logic in_lines, in_ticks, lit_row, pat_lit;

    always_ff @(posedge clk) begin
        if (rst)            pat_q <= PAT_DARK;
        else if (frame_end) pat_q <= pattern_e'(pat_sel);
    end

    always_comb begin
        in_lines = (line_q >= FIRST_L) && (line_q < END_L);
        in_ticks = (tick_q >= START_T);
        lit_row  = (row_q < LIT_R);
        unique case (pat_q)
            PAT_BARS:  pat_lit = bar_lit(int'(tick_q) - VIDEO_START, BAR_TICKS);
            PAT_SOLID: pat_lit = 1'b1;
            default:   pat_lit = 1'b0;
        endcase
        video = in_lines && in_ticks && lit_row && pat_lit;
    end
endmodule

// File: rtl/crt_drive_gen.sv
module crt_drive_gen
    import crt_pkg::*;
#(
    parameter int LINE_TICKS   = DEF_LINE_TICKS,
    parameter int HDRIVE_TICKS = DEF_HDRIVE_TICKS,
    parameter int FRAME_LINES  = DEF_FRAME_LINES,
    parameter int VDRIVE_LINES = DEF_VDRIVE_LINES,
    parameter int VDRIVE_DELAY = DEF_VDRIVE_DELAY,
    parameter int VIDEO_START  = DEF_VIDEO_START,
    parameter int ACTIVE_FIRST = DEF_ACTIVE_FIRST,
    parameter int ACTIVE_LINES = DEF_ACTIVE_LINES,
    parameter int ROW_LINES    = DEF_ROW_LINES,
    parameter int LIT_LINES    = DEF_LIT_LINES,
    parameter int BAR_TICKS    = DEF_BAR_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [1:0] pat_sel,
    output logic       hdrive_n,
    output logic       vdrive_n,
    output logic       video
);
    localparam int TW = $clog2(LINE_TICKS);
    localparam int LW = $clog2(FRAME_LINES);
    localparam int RW = $clog2(ROW_LINES);
    localparam logic [TW-1:0] H_T  = TW'(HDRIVE_TICKS);
    localparam logic [TW-1:0] D_T  = TW'(VDRIVE_DELAY);
    localparam logic [LW-1:0] VL_L = LW'(VDRIVE_LINES);

    logic [TW-1:0] tick_q;
    logic [LW-1:0] line_q;
    logic [RW-1:0] row_q;
    logic          line_end, frame_end, video_raw;
    pattern_e      pat_q;
    drive_t        drv;

    crt_tick_ctr #(.LINE_TICKS(LINE_TICKS)) u_tick (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .tick_q(tick_q), .line_end(line_end)
    );

    crt_line_ctr #(
        .FRAME_LINES(FRAME_LINES), .ACTIVE_FIRST(ACTIVE_FIRST), .ROW_LINES(ROW_LINES)
    ) u_line (
        .clk(clk), .rst(rst), .line_end(line_end),
        .line_q(line_q), .row_q(row_q), .frame_end(frame_end)
    );

    crt_pattern_gen #(
        .LINE_TICKS(LINE_TICKS), .FRAME_LINES(FRAME_LINES), .VIDEO_START(VIDEO_START),
        .ACTIVE_FIRST(ACTIVE_FIRST), .ACTIVE_LINES(ACTIVE_LINES), .ROW_LINES(ROW_LINES),
        .LIT_LINES(LIT_LINES), .BAR_TICKS(BAR_TICKS)
    ) u_pat (
        .clk(clk), .rst(rst), .frame_end(frame_end), .pat_sel(pat_sel),
        .tick_q(tick_q), .line_q(line_q), .row_q(row_q),
        .pat_q(pat_q), .video(video_raw)
    );

    // Vertical pulse spans the frame start, offset from the line start.
    always_comb begin
        drv.hdrive_n = !(tick_q < H_T);
        drv.vdrive_n = !(((line_q == '0) && (tick_q >= D_T)) ||
                         ((line_q != '0) && (line_q < VL_L)) ||
                         ((line_q == VL_L) && (tick_q < D_T)));
        drv.video    = video_raw;
    end

    assign hdrive_n = drv.hdrive_n;
    assign vdrive_n = drv.vdrive_n;
    assign video    = drv.video;
endmodule

// File: rtl/crt_drive_gen_chk.sv
module crt_drive_gen_chk #(
    parameter int LINE_TICKS   = 50,
    parameter int HDRIVE_TICKS = 15,
    parameter int FRAME_LINES  = 400,
    parameter int VDRIVE_LINES = 16,
    parameter int VDRIVE_DELAY = 9,
    parameter int VIDEO_START  = 10,
    parameter int ACTIVE_FIRST = 80,
    parameter int ACTIVE_LINES = 250,
    parameter int ROW_LINES    = 10,
    parameter int LIT_LINES    = 8,
    localparam int TW = $clog2(LINE_TICKS),
    localparam int LW = $clog2(FRAME_LINES)
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_en,
    input logic          hdrive_n,
    input logic          vdrive_n,
    input logic          video,
    input logic [TW-1:0] tick_q,
    input logic [LW-1:0] line_q,
    input logic [1:0]    pat_q
);
    // R1: tick count wraps after the last tick of a line
    p_tick_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && int'(tick_q) == LINE_TICKS - 1) |=> (tick_q == '0));

    // R1: horizontal drive releases on its programmed tick
    p_hdrive_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(hdrive_n) |-> (int'(tick_q) == HDRIVE_TICKS));

    // R2: line count wraps after the last line of a frame
    p_line_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && int'(tick_q) == LINE_TICKS - 1 && int'(line_q) == FRAME_LINES - 1)
        |=> (line_q == '0));

    // R3: vertical drive falls and rises at fixed positions
    p_vdrive_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(vdrive_n) |-> (line_q == '0 && int'(tick_q) == VDRIVE_DELAY));
    p_vdrive_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(vdrive_n) |-> (int'(line_q) == VDRIVE_LINES && int'(tick_q) == VDRIVE_DELAY));

    // R4: video confined to the active window
    p_video_window_r4: assert property (@(posedge clk) disable iff (rst)
        video |-> (int'(tick_q) >= VIDEO_START && int'(line_q) >= ACTIVE_FIRST &&
                   int'(line_q) < ACTIVE_FIRST + ACTIVE_LINES));

    // R6: spacer lines of each character row stay dark
    p_row_gap_r6: assert property (@(posedge clk) disable iff (rst)
        video |-> (((int'(line_q) - ACTIVE_FIRST) % ROW_LINES) < LIT_LINES));

    // R8: pattern register only changes as the frame wraps
    p_pat_frame_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(pat_q) |-> (line_q == '0 && tick_q == '0));

    // R9: outputs frozen while the enable is low
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(hdrive_n) && $stable(vdrive_n) && $stable(video)));
endmodule

bind crt_drive_gen crt_drive_gen_chk #(
    .LINE_TICKS(LINE_TICKS), .HDRIVE_TICKS(HDRIVE_TICKS), .FRAME_LINES(FRAME_LINES),
    .VDRIVE_LINES(VDRIVE_LINES), .VDRIVE_DELAY(VDRIVE_DELAY), .VIDEO_START(VIDEO_START),
    .ACTIVE_FIRST(ACTIVE_FIRST), .ACTIVE_LINES(ACTIVE_LINES), .ROW_LINES(ROW_LINES),
    .LIT_LINES(LIT_LINES)
) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .hdrive_n(hdrive_n), .vdrive_n(vdrive_n), .video(video),
    .tick_q(tick_q), .line_q(line_q), .pat_q(pat_q)
);

// File: tb/crt_drive_gen_test.sv
`timescale 1ns/1ps
module crt_drive_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] pat_sel = 2'd2;
    logic       hdrive_n, vdrive_n, video;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_tick = 0, m_line = 0, m_pat = 0, m_frames = 0;
    longint tcnt = 0;
    longint last_hfall = -1, last_vfall = -1;
    logic prev_h = 1'b0, prev_v = 1'b1;

    always #10 clk = ~clk;

    crt_drive_gen uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .pat_sel(pat_sel),
        .hdrive_n(hdrive_n), .vdrive_n(vdrive_n), .video(video)
    );

    // Reference position tracker built from R1, R2, R7, R8
    always @(posedge clk) begin
        if (rst) begin
            m_tick <= 0; m_line <= 0; m_pat <= 0; m_frames <= 0;
        end else if (tick_en) begin
            tcnt <= tcnt + 1;
            if (m_tick == 49) begin
                m_tick <= 0;
                if (m_line == 399) begin
                    m_line <= 0; m_pat <= int'(pat_sel); m_frames <= m_frames + 1;
                end else m_line <= m_line + 1;
            end else m_tick <= m_tick + 1;
        end
    end

    function automatic bit exp_video(int ln, int tk, int pat);
        if (ln < 80 || ln >= 330 || tk < 10) return 0;
        if (((ln - 80) % 10) >= 8) return 0;
        case (pat)
            1: return (((tk - 10) / 4) % 2) == 0;
            2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_vdrive_n(int ln, int tk);
        int pos = ln * 50 + tk;
        return !(pos >= 9 && pos < 809);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors <= 20)
                $display("FAIL %s line=%0d tick=%0d actual=%b expected=%b",
                         req, m_line, m_tick, act, exp);
        end
    endtask

    task automatic check_cycle();
        string vreq;
        bit ev;
        check("R1 hdrive", hdrive_n, (m_tick < 15) ? 1'b0 : 1'b1);
        check("R2 vdrive", vdrive_n, exp_vdrive_n(m_line, m_tick));
        ev = exp_video(m_line, m_tick, m_pat);
        if (m_line < 80 || m_line >= 330 || m_tick < 10) vreq = "R4 window";
        else if (((m_line - 80) % 10) >= 8)              vreq = "R6 row gap";
        else if (m_frames == 0)                          vreq = "R7 reset pattern";
        else if (int'(pat_sel) != m_pat)                 vreq = "R8 late select";
        else                                             vreq = "R5 pattern";
        check(vreq, video, ev);
        // Edge positions and periods measured in accepted ticks
        if (prev_h && !hdrive_n) begin
            if (last_hfall >= 0) check("R1 period", (tcnt - last_hfall) == 50, 1'b1);
            last_hfall = tcnt;
        end
        if (!prev_h && hdrive_n) check("R1 rise tick", m_tick == 15, 1'b1);
        if (prev_v && !vdrive_n) begin
            check("R3 fall pos", (m_line == 0 && m_tick == 9), 1'b1);
            if (last_vfall >= 0) check("R2 frame period", (tcnt - last_vfall) == 20000, 1'b1);
            last_vfall = tcnt;
        end
        if (!prev_v && vdrive_n) check("R3 rise pos", (m_line == 16 && m_tick == 9), 1'b1);
        prev_h = hdrive_n;
        prev_v = vdrive_n;
    endtask

    task automatic step(input int pct);
        @(negedge clk);
        check_cycle();
        tick_en = (($urandom % 100) < pct);
    endtask

    initial begin
        logic sh, sv, sx;
        void'($urandom(32'd20240601));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state with no enable yet
        check("R7 hdrive", hdrive_n, 1'b0);
        check("R7 vdrive", vdrive_n, 1'b1);
        check("R7 video", video, 1'b0);
        prev_h = hdrive_n; prev_v = vdrive_n;
        pat_sel = 2'd1;
        while (m_frames < 1) step(85);
        // Frame 1 shows bars; change select mid-frame (R8)
        while (m_line < 200) step(85);
        pat_sel = 2'd2;
        while (m_frames < 2) step(85);
        // Frame 2 solid; freeze enable inside active area (R9)
        while (m_line < 100 || m_tick < 20) step(90);
        @(negedge clk);
        check_cycle();
        tick_en = 1'b0;
        @(negedge clk);
        sh = hdrive_n; sv = vdrive_n; sx = video;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check("R9 hold h", hdrive_n, sh);
            check("R9 hold v", vdrive_n, sv);
            check("R9 hold video", video, sx);
        end
        pat_sel = 2'd3;
        while (m_frames < 3) step(85);
        // Frame 3: code 3 is dark (R5)
        while (m_line < 120) step(100);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(64'd200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at line=%0d tick=%0d", m_line, m_tick);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule